// File: doc/BRIEF.md
# Software-Driven Two-Wire Bus Port

This block is an APB slave that gives software direct control over the clock line and the data line of a two-wire serial bus. Each line has one output bit. Clearing the bit turns on a pull-down enable that holds the line low. Setting the bit turns the pull-down off, and an external resistor then pulls the line high. The block never drives a line high. A set address and a clear address let software change one line without first reading the state of the other.

A read returns the level measured on the pads, not the stored output bits. The pads pass through a synchroniser before they reach the read data. A line that another device on the bus is holding low therefore reads as 0, even when this block has released it. Software uses this to detect clock stretching and to receive data. Before it samples the incoming data bit, software must release the data line.

The block has no protocol logic. Software generates start and stop conditions, bit timing and acknowledge handling by toggling the bits.

Top module: `twb_port_apb`

## Requirements
- R1: A read at byte offset 0x000 returns the synchronised clock-line level in bit 0 and the synchronised data-line level in bit 1. Bits 31 down to 2 read as zero.
- R2: A write at byte offset 0x000 sets every output bit whose matching write-data bit is 1 (bit 0 is clock, bit 1 is data). Output bits whose write-data bit is 0 keep their value.
- R3: A write at byte offset 0x004 clears every output bit whose matching write-data bit is 1 (bit 0 is clock, bit 1 is data). Output bits whose write-data bit is 0 keep their value.
- R4: After reset both output bits are 0, so both pull-down enables are asserted. A read at 0x000 then returns 0 once the synchroniser has settled.
- R5: Each pull-down enable output is the inverse of its output bit. A value of 1 means "pull the line low" and a value of 0 means "release the line".
- R6: The read data passes each pad level through SYNC_STAGES flip-flops (2 by default). A change on a pad appears in the read data after exactly two rising clock edges. A line that another device holds low reads as 0 even when its output bit is 1.
- R7: A read at any offset other than 0x000 (0x004 included) returns zero. A write at any offset other than 0x000 or 0x004 leaves both output bits unchanged. Reads never change the output bits.
- R8: pready is always high, so every transfer completes in its access phase without wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | APB reset, active low |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (12) | Byte address |
| pwdata | input | DATA_W (32) | Write data |
| prdata | output | DATA_W (32) | Read data: pad levels at offset 0x000 |
| pready | output | 1 | Always 1 |
| scl_pull_o | output | 1 | Clock-line pull-down enable, active high |
| sda_pull_o | output | 1 | Data-line pull-down enable, active high |
| scl_pad_i | input | 1 | Clock-line pad level |
| sda_pad_i | input | 1 | Data-line pad level |

## Verification
A set or clear write can change an output bit on the same clock edge at which the external device releases or grabs the same line. The bench provokes this in two ways. A directed case drops the modelled device's hold on the clock line in the access phase of a set write. The random phase also changes the device holds between operations. The bench judges each case after the synchroniser has settled: it compares the read data with the AND of its own shadow of the output bits and the inverse of the device holds. Any premature, late or lost transition then appears as a wrong level.

// File: rtl/twb_pkg.sv
package twb_pkg;

   // Write operation decoded from one APB access phase
   typedef enum logic [1:0] {
      TWB_OP_NONE = 2'b00,
      TWB_OP_SET  = 2'b01,
      TWB_OP_CLR  = 2'b10
   } twb_op_e;

   // Bit position of each line in the data word (software-visible order)
   localparam int TWB_CLK_BIT  = 0;
   localparam int TWB_DAT_BIT  = 1;
   localparam int TWB_NUM_LINE = 2;

endpackage

// File: rtl/twb_apb_decode.sv
module twb_apb_decode
   import twb_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int SET_OFFSET = 'h000,
   parameter int CLR_OFFSET = 'h004
) (
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   output twb_op_e           wr_op,
   output logic              rd_lvl
);

   localparam logic [ADDR_W-1:0] SetAddr = ADDR_W'(SET_OFFSET);
   localparam logic [ADDR_W-1:0] ClrAddr = ADDR_W'(CLR_OFFSET);

   logic wr_acc;
   assign wr_acc = psel & penable & pwrite;

   always_comb begin
      wr_op = TWB_OP_NONE;
      if (wr_acc) begin
         if (paddr == SetAddr)      wr_op = TWB_OP_SET;
         else if (paddr == ClrAddr) wr_op = TWB_OP_CLR;
      end
   end

   // The level readback lives at the set address; the clear address reads zero
   assign rd_lvl = psel & ~pwrite & (paddr == SetAddr);

endmodule

// File: rtl/twb_line_ctl.sv
module twb_line_ctl
   import twb_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  twb_op_e wr_op,
   input  logic    wbit,
   output logic    out_bit,
   output logic    pull_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_bit <= 1'b0;
      end else if (wbit) begin
         unique case (wr_op)
            TWB_OP_SET: out_bit <= 1'b1;
            TWB_OP_CLR: out_bit <= 1'b0;
            default:    out_bit <= out_bit;
         endcase
      end
   end

   // Open drain: the only active drive is toward ground
   assign pull_o = ~out_bit;

endmodule

// File: rtl/twb_sync.sv
module twb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/twb_port_apb.sv
module twb_port_apb
   import twb_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2,
   parameter int SET_OFFSET  = 'h000,
   parameter int CLR_OFFSET  = 'h004
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output logic              pready,
   output logic              scl_pull_o,
   output logic              sda_pull_o,
   input  logic              scl_pad_i,
   input  logic              sda_pad_i
);

   localparam int Lines = TWB_NUM_LINE;

   // Elaboration-time parameter checks
   if (DATA_W < Lines) begin : g_bad_width
      $error("twb_port_apb: DATA_W must hold both line bits");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("twb_port_apb: SYNC_STAGES must be at least 2");
   end
   if (SET_OFFSET == CLR_OFFSET) begin : g_bad_map
      $error("twb_port_apb: set and clear offsets must differ");
   end
   if ((SET_OFFSET % 4) != 0 || (CLR_OFFSET % 4) != 0) begin : g_bad_align
      $error("twb_port_apb: offsets must be word aligned");
   end
   if (SET_OFFSET >= (1 << ADDR_W) || CLR_OFFSET >= (1 << ADDR_W)) begin : g_bad_range
      $error("twb_port_apb: offsets exceed the address width");
   end

   twb_op_e          wr_op;
   logic             rd_lvl;
   logic [Lines-1:0] pad_v;
   logic [Lines-1:0] lvl_v;
   logic [Lines-1:0] pull_v;
   logic [Lines-1:0] out_v;

   assign pad_v[TWB_CLK_BIT] = scl_pad_i;
   assign pad_v[TWB_DAT_BIT] = sda_pad_i;

   twb_apb_decode #(
      .ADDR_W     (ADDR_W),
      .SET_OFFSET (SET_OFFSET),
      .CLR_OFFSET (CLR_OFFSET)
   ) u_dec (
      .psel    (psel),
      .penable (penable),
      .pwrite  (pwrite),
      .paddr   (paddr),
      .wr_op   (wr_op),
      .rd_lvl  (rd_lvl)
   );

   for (genvar g = 0; g < Lines; g++) begin : g_line
      twb_line_ctl u_ctl (
         .clk     (pclk),
         .rst_n   (presetn),
         .wr_op   (wr_op),
         .wbit    (pwdata[g]),
         .out_bit (out_v[g]),
         .pull_o  (pull_v[g])
      );

      twb_sync #(
         .STAGES (SYNC_STAGES)
      ) u_sync (
         .clk   (pclk),
         .rst_n (presetn),
         .d     (pad_v[g]),
         .q     (lvl_v[g])
      );
   end

   assign scl_pull_o = pull_v[TWB_CLK_BIT];
   assign sda_pull_o = pull_v[TWB_DAT_BIT];

   always_comb begin
      prdata = '0;
      if (rd_lvl) prdata[Lines-1:0] = lvl_v;
   end

   assign pready = 1'b1;

endmodule

// File: rtl/twb_port_apb_chk.sv
module twb_port_apb_chk #(
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2,
   parameter int SET_OFFSET  = 'h000,
   parameter int CLR_OFFSET  = 'h004
) (
   input logic              pclk,
   input logic              presetn,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [ADDR_W-1:0] paddr,
   input logic [DATA_W-1:0] pwdata,
   input logic [DATA_W-1:0] prdata,
   input logic              scl_pull_o,
   input logic              sda_pull_o,
   input logic              scl_pad_i,
   input logic              sda_pad_i
);

   logic wr_acc, set_acc, clr_acc, lvl_rd;
   assign wr_acc  = psel && penable && pwrite;
   assign set_acc = wr_acc && (paddr == ADDR_W'(SET_OFFSET));
   assign clr_acc = wr_acc && (paddr == ADDR_W'(CLR_OFFSET));
   assign lvl_rd  = psel && !pwrite && (paddr == ADDR_W'(SET_OFFSET));

   // R2
   set_clk_chk: assert property (@(posedge pclk) disable iff (!presetn)
      set_acc && pwdata[0] |=> !scl_pull_o);
   // R2
   set_keep_chk: assert property (@(posedge pclk) disable iff (!presetn)
      set_acc && !pwdata[1] |=> $stable(sda_pull_o));
   // R3
   clr_dat_chk: assert property (@(posedge pclk) disable iff (!presetn)
      clr_acc && pwdata[1] |=> sda_pull_o);
   // R3
   clr_keep_chk: assert property (@(posedge pclk) disable iff (!presetn)
      clr_acc && !pwdata[0] |=> $stable(scl_pull_o));
   // R7
   idle_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
      !set_acc && !clr_acc |=> $stable({sda_pull_o, scl_pull_o}));
   // R1
   upper_zero_chk: assert property (@(posedge pclk) disable iff (!presetn)
      psel && !pwrite |-> prdata[DATA_W-1:2] == '0);

   if (SYNC_STAGES == 2) begin : g_lat
      // R6
      rd_latency_chk: assert property (@(posedge pclk) disable iff (!presetn)
         lvl_rd |-> prdata[1:0] == {$past(sda_pad_i, 2), $past(scl_pad_i, 2)});
   end

endmodule

bind twb_port_apb twb_port_apb_chk #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .SYNC_STAGES (SYNC_STAGES),
   .SET_OFFSET  (SET_OFFSET),
   .CLR_OFFSET  (CLR_OFFSET)
) u_chk (
   .pclk       (pclk),
   .presetn    (presetn),
   .psel       (psel),
   .penable    (penable),
   .pwrite     (pwrite),
   .paddr      (paddr),
   .pwdata     (pwdata),
   .prdata     (prdata),
   .scl_pull_o (scl_pull_o),
   .sda_pull_o (sda_pull_o),
   .scl_pad_i  (scl_pad_i),
   .sda_pad_i  (sda_pad_i)
);

// File: tb/tb_twb_port_apb.sv
module tb_twb_port_apb;

   localparam int CLK_PERIOD = 10;
   localparam int SYNC       = 2;
   localparam int WATCHDOG   = 20000;

   logic        pclk = 1'b0;
   logic        presetn = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready;
   logic        scl_pull_o, sda_pull_o;
   logic        scl_pad, sda_pad;
   logic        dev_scl_low = 1'b0, dev_sda_low = 1'b0;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   logic [1:0] shadow = 2'b00;

   // Wired-AND bus with pull-up: low if either side pulls
   assign scl_pad = !(scl_pull_o || dev_scl_low);
   assign sda_pad = !(sda_pull_o || dev_sda_low);

   twb_port_apb dut (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o),
      .scl_pad_i(scl_pad), .sda_pad_i(sda_pad)
   );

   always #(CLK_PERIOD/2) pclk = ~pclk;

   function automatic logic [1:0] next_out(input logic [1:0] cur, input int op,
                                           input logic [1:0] d);
      if (op == 0)      return cur | d;
      else if (op == 1) return cur & ~d;
      else              return cur;
   endfunction

   function automatic logic [1:0] bus_level(input logic [1:0] out, input logic [1:0] hold);
      return out & ~hold;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge pclk);
      psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
      @(negedge pclk);
      penable = 1;
      @(negedge pclk);
      psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge pclk);
      psel = 1; pwrite = 0; paddr = a; penable = 0;
      @(negedge pclk);
      penable = 1;
      #1 d = prdata;
      check("R8 pready", {31'b0, pready}, 32'h1);
      @(negedge pclk);
      psel = 0; penable = 0;
   endtask

   task automatic settle();
      repeat (SYNC + 1) @(negedge pclk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge pclk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin : main
      logic [31:0] rd;
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'h1C0FFEE);

      repeat (4) @(negedge pclk);
      presetn = 1;
      @(negedge pclk);

      // R4 reset state: both pull-downs on, lines read low
      check("R4 pulls after reset", {30'b0, sda_pull_o, scl_pull_o}, 32'h3);
      settle();
      apb_read(12'h000, rd);
      check("R4 readback after reset", rd, 32'h0);

      // R2 set clock bit only; R5 pull enable follows inverse
      apb_write(12'h000, 32'h1); shadow = next_out(shadow, 0, 2'b01);
      check("R5 scl release", {31'b0, scl_pull_o}, 32'h0);
      check("R2 sda untouched", {31'b0, sda_pull_o}, 32'h1);
      settle(); apb_read(12'h000, rd);
      check("R1 clock level bit0", rd, 32'h1);

      // R2 set data, extra upper write bits ignored
      apb_write(12'h000, 32'hFFFF_FFFE); shadow = next_out(shadow, 0, 2'b10);
      settle(); apb_read(12'h000, rd);
      check("R1 both levels and upper zero", rd, 32'h3);

      // R3 clear clock only
      apb_write(12'h004, 32'h1); shadow = next_out(shadow, 1, 2'b01);
      check("R3 clock pulled", {30'b0, sda_pull_o, scl_pull_o}, 32'h1);
      settle(); apb_read(12'h000, rd);
      check("R3 readback after clear", rd, 32'h2);

      // R7 write to unmapped offset ignored; read of clear address is zero
      apb_write(12'h008, 32'h3);
      check("R7 unmapped write no effect", {30'b0, sda_pull_o, scl_pull_o}, 32'h1);
      apb_read(12'h004, rd);
      check("R7 clear address reads zero", rd, 32'h0);
      apb_read(12'h00C, rd);
      check("R7 other offset reads zero", rd, 32'h0);

      // R6 clock stretching: released clock held low by the device
      apb_write(12'h000, 32'h1); shadow = next_out(shadow, 0, 2'b01);
      dev_scl_low = 1;
      settle(); apb_read(12'h000, rd);
      check("R6 stretched clock reads low", rd, 32'h2);
      dev_scl_low = 0;
      settle(); apb_read(12'h000, rd);
      check("R6 clock after stretch", rd, 32'h3);

      // R6 latency: data from device shows after exactly two edges
      @(negedge pclk);
      psel = 1; pwrite = 0; paddr = 12'h000; penable = 1;
      dev_sda_low = 1;
      @(negedge pclk); #1;
      check("R6 one edge old level", {30'b0, prdata[1:0]}, 32'h3);
      @(negedge pclk); #1;
      check("R6 two edges new level", {30'b0, prdata[1:0]}, 32'h1);
      psel = 0; penable = 0;
      dev_sda_low = 0;

      // Same-cycle: set write while device releases the clock line
      apb_write(12'h004, 32'h1); shadow = next_out(shadow, 1, 2'b01);
      dev_scl_low = 1;
      @(negedge pclk);
      psel = 1; pwrite = 1; paddr = 12'h000; pwdata = 32'h1; penable = 0;
      @(negedge pclk);
      penable = 1; dev_scl_low = 0;
      @(negedge pclk);
      psel = 0; penable = 0; pwrite = 0;
      shadow = next_out(shadow, 0, 2'b01);
      settle(); apb_read(12'h000, rd);
      check("R2 R6 set with concurrent release", rd, {30'b0, bus_level(shadow, 2'b00)});

      // Random phase
      for (int i = 0; i < 80; i++) begin
         int op;
         logic [1:0] d, hold;
         logic [11:0] a;
         op = int'($urandom % 3);
         d = 2'($urandom);
         hold = 2'($urandom);
         a = (op == 0) ? 12'h000 : (op == 1) ? 12'h004 : 12'h010;
         dev_scl_low = hold[0]; dev_sda_low = hold[1];
         apb_write(a, {$urandom, 2'b00} | {30'b0, d});
         shadow = next_out(shadow, op, d);
         check("R5 random pulls", {30'b0, sda_pull_o, scl_pull_o}, {30'b0, ~shadow});
         settle(); apb_read(12'h000, rd);
         check("R1 R2 R3 random readback", rd, {30'b0, bus_level(shadow, hold)});
      end

      finish_run();
   end

endmodule